// File: doc/BRIEF.md
# UART Serial Transmitter

This block turns characters held in an external transmit FIFO into an asynchronous serial bit stream on a single output line. Whenever the FIFO holds data and the line is free, the block pops one entry. It then shifts out a frame: a low start bit, the data bits least significant first, an optional parity bit, and one or two high stop bits. If more data is waiting at the end of the final stop bit, the next frame follows with no idle gap. The line rests high between frames.

Bit timing comes from an internal tick generator. The generator divides the system clock by a 16-bit divisor to produce an enable at sixteen times the bit rate, so every bit of a frame lasts sixteen ticks. A divisor of zero stops the ticks altogether.

The settings are the character length (5 to 8 bits), parity on or off, the parity sense, the stop-bit count and a global enable. They are sampled at the moment a character is popped and stay fixed for that frame. A busy output marks the span from the start bit to the end of the last stop bit.

The state machine has five states:
- IDLE: the line is high.
- START: the start bit.
- DATA: the character bits.
- PARITY: the parity bit.
- STOP: one or two stop bits.

Its transitions are:
- IDLE→START on a pop.
- START→DATA after sixteen ticks.
- DATA→DATA until the last character bit.
- DATA→PARITY when parity is on, or DATA→STOP when it is off.
- PARITY→STOP after sixteen ticks.
- STOP→STOP for the second stop bit.
- STOP→START when another pop happens at the end of the frame.
- STOP→IDLE when no pop happens at the end of the frame.

Top module: `uart_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `txd` is high and `busy` is low.
- R2: A frame begins with a start bit that drives `txd` low.
- R3: The start bit is followed by the character bits, least significant first. The number of bits is 5 + `cfg_len`, so `cfg_len` values 0, 1, 2 and 3 give 5, 6, 7 and 8 bits. Bit i of `fifo_data` is sent as the i-th data bit.
- R4: When `cfg_par_en` is 1, one parity bit follows the data bits. With `cfg_par_odd`=0 (even parity), the total number of ones across the data bits and the parity bit is even. With `cfg_par_odd`=1 it is odd. When `cfg_par_en` is 0, no parity bit is sent.
- R5: The frame ends with high stop bits: one stop bit when `cfg_two_stop` is 0, two when it is 1.
- R6: `fifo_pop` is high for single cycles only. It rises only when all of the following hold: `fifo_empty` is 0, `cfg_en` is 1, `divisor` is nonzero, and the block is either idle or in the final tick of its last stop bit. When data is waiting at the end of a frame, the next start bit follows immediately.
- R7: `busy` is high from the first cycle of the start bit until the last stop bit has ended.
- R8: A baud tick occurs once every `divisor` clock cycles, and each bit of a frame lasts exactly sixteen ticks. `txd` changes only on a tick or on a pop.
- R9: While `divisor` is 0, no ticks occur. A frame in progress freezes, with `txd` and `busy` held.
- R10: While `cfg_en` is 0, no character is popped. A frame already under way still completes.
- R11: The length, parity and stop settings are captured at the pop. Changing them during a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en | input | 1 | Allows new frames to start |
| cfg_len | input | 2 | Character length select: 5 + value bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_two_stop | input | 1 | 1 = two stop bits, 0 = one |
| divisor | input | 16 | Clock cycles per baud tick; 0 stops ticks |
| fifo_empty | input | 1 | Transmit FIFO holds no data |
| fifo_data | input | 8 | Character at the FIFO head |
| fifo_pop | output | 1 | Consume the FIFO head this cycle |
| txd | output | 1 | Serial output line |
| busy | output | 1 | Frame in progress |

## Verification
The in-line assertions check the following on every cycle:
- the start bit is low when `busy` rises;
- the bit before `busy` falls is high;
- pops are single-cycle and never occur on an empty FIFO;
- ticks are spaced by the divisor;
- the line never moves without a tick or a pop;
- the frame freezes while the divisor is zero.

Some behaviour only the bench scenarios can show: the exact bit order and length for each character-length setting, the parity values, the stop counts, back-to-back framing, the effect of `cfg_en`, and the independence of a frame from mid-frame setting changes. The bench shows these by comparing every cycle against a frame-level reference model.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    localparam int CHAR_W    = 8;
    localparam int LEN_SEL_W = 2;
    localparam int MIN_BITS  = CHAR_W - (2 ** LEN_SEL_W - 1);
    localparam int OVS       = 16;
    localparam int DIV_W     = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_e;

    // Parity over the active character bits; odd sense inverts the result.
    function automatic logic frame_parity(input logic [CHAR_W-1:0]    d,
                                          input logic [LEN_SEL_W-1:0] sel,
                                          input logic                 odd);
        logic acc;
        acc = odd;
        for (int i = 0; i < CHAR_W; i++) begin
            if (i < MIN_BITS + int'(sel)) acc = acc ^ d[i];
        end
        return acc;
    endfunction

endpackage

// File: rtl/uart_tx_baud.sv
module uart_tx_baud
    import uart_tx_pkg::*;
#(
    parameter int W = DIV_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] divisor,
    output logic         tick
);

    logic [W-1:0] cnt;

    always_comb begin
        tick = (divisor != '0) && (cnt >= divisor - 1'b1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (divisor == '0 || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R8: with a steady divisor above one, two ticks never fall on adjacent cycles
    a_r8_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && divisor > 1) |=> (!tick || divisor != $past(divisor)));

endmodule

// File: rtl/uart_tx_fsm.sv
module uart_tx_fsm
    import uart_tx_pkg::*;
#(
    parameter int CW = CHAR_W,
    parameter int SW = LEN_SEL_W,
    parameter int OV = OVS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          div_ok,
    input  logic          cfg_en,
    input  logic [SW-1:0] cfg_len,
    input  logic          cfg_par_en,
    input  logic          cfg_par_odd,
    input  logic          cfg_two_stop,
    input  logic          fifo_empty,
    input  logic [CW-1:0] fifo_data,
    output logic          fifo_pop,
    output logic          txd,
    output logic          busy
);

    localparam int SUB_W    = $clog2(OV);
    localparam int IDX_W    = $clog2(CW);
    localparam int MIN_LAST = CW - (2 ** SW);

    tx_state_e        state, state_nxt;
    logic [SUB_W-1:0] sub;
    logic [IDX_W-1:0] bit_idx;
    logic [IDX_W-1:0] last_idx;
    logic             stop_idx;
    logic [CW-1:0]    shreg;
    logic             par_bit;
    logic             par_en_q;
    logic             two_stop_q;
    logic             bit_end;
    logic             last_stop;

    assign bit_end   = tick && (sub == SUB_W'(OV - 1));
    assign last_stop = (state == ST_STOP) && bit_end && (!two_stop_q || stop_idx);
    assign fifo_pop  = cfg_en && div_ok && !fifo_empty &&
                       ((state == ST_IDLE) || last_stop);

    // Next-state decision
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:   if (fifo_pop) state_nxt = ST_START;
            ST_START:  if (bit_end)  state_nxt = ST_DATA;
            ST_DATA:   if (bit_end && bit_idx == last_idx)
                           state_nxt = par_en_q ? ST_PARITY : ST_STOP;
            ST_PARITY: if (bit_end)  state_nxt = ST_STOP;
            ST_STOP:   if (last_stop) state_nxt = fifo_pop ? ST_START : ST_IDLE;
            default:   state_nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Frame datapath: settings and character are captured at the pop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sub        <= '0;
            bit_idx    <= '0;
            last_idx   <= '0;
            stop_idx   <= 1'b0;
            shreg      <= '0;
            par_bit    <= 1'b0;
            par_en_q   <= 1'b0;
            two_stop_q <= 1'b0;
        end else if (fifo_pop) begin
            sub        <= '0;
            bit_idx    <= '0;
            last_idx   <= IDX_W'(MIN_LAST) + IDX_W'(cfg_len);
            stop_idx   <= 1'b0;
            shreg      <= fifo_data;
            par_bit    <= frame_parity(fifo_data, cfg_len, cfg_par_odd);
            par_en_q   <= cfg_par_en;
            two_stop_q <= cfg_two_stop;
        end else if (state != ST_IDLE && tick) begin
            sub <= bit_end ? '0 : sub + 1'b1;
            if (bit_end && state == ST_DATA) begin
                shreg   <= shreg >> 1;
                bit_idx <= bit_idx + 1'b1;
            end
            if (bit_end && state == ST_STOP) stop_idx <= 1'b1;
        end
    end

    // Outputs
    always_comb begin
        txd  = 1'b1;
        busy = 1'b1;
        unique case (state)
            ST_IDLE:   busy = 1'b0;
            ST_START:  txd  = 1'b0;
            ST_DATA:   txd  = shreg[0];
            ST_PARITY: txd  = par_bit;
            ST_STOP:   txd  = 1'b1;
            default:   busy = 1'b0;
        endcase
    end

    // R2: the first cycle of a frame drives the start level
    a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !txd);

    // R5: the bit that ends a frame is a high stop bit
    a_r5_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(txd));

    // R6: a pop never targets an empty FIFO
    a_r6_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> !fifo_empty);

    // R6: pops are single-cycle pulses
    a_r6_single_pop: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |=> !fifo_pop);

endmodule

// File: rtl/uart_tx.sv
module uart_tx
    import uart_tx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_en,
    input  logic [LEN_SEL_W-1:0] cfg_len,
    input  logic                 cfg_par_en,
    input  logic                 cfg_par_odd,
    input  logic                 cfg_two_stop,
    input  logic [DIV_W-1:0]     divisor,
    input  logic                 fifo_empty,
    input  logic [CHAR_W-1:0]    fifo_data,
    output logic                 fifo_pop,
    output logic                 txd,
    output logic                 busy
);

    logic baud_tick;
    logic div_ok;

    assign div_ok = (divisor != '0);

    uart_tx_baud #(.W(DIV_W)) u_baud (
        .clk     (clk),
        .rst_n   (rst_n),
        .divisor (divisor),
        .tick    (baud_tick)
    );

    uart_tx_fsm #(.CW(CHAR_W), .SW(LEN_SEL_W), .OV(OVS)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (baud_tick),
        .div_ok       (div_ok),
        .cfg_en       (cfg_en),
        .cfg_len      (cfg_len),
        .cfg_par_en   (cfg_par_en),
        .cfg_par_odd  (cfg_par_odd),
        .cfg_two_stop (cfg_two_stop),
        .fifo_empty   (fifo_empty),
        .fifo_data    (fifo_data),
        .fifo_pop     (fifo_pop),
        .txd          (txd),
        .busy         (busy)
    );

    // R8: the line only moves on a baud tick or when a character is taken
    a_r8_line_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (!baud_tick && !fifo_pop) |=> $stable(txd));

    // R9: a zero divisor freezes the frame
    a_r9_frozen_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (divisor == '0) |=> ($stable(txd) && $stable(busy)));

endmodule

// File: tb/uart_tx_test.sv
`timescale 1ns/1ps
module uart_tx_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_en = 1'b0;
    logic [1:0]  cfg_len = 2'd3;
    logic        cfg_par_en = 1'b0;
    logic        cfg_par_odd = 1'b0;
    logic        cfg_two_stop = 1'b0;
    logic [15:0] divisor = 16'd1;
    logic        fifo_empty;
    logic [7:0]  fifo_data;
    logic        fifo_pop;
    logic        txd;
    logic        busy;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [7:0] fmem [0:63];
    int wr_i = 0;
    int rd_i = 0;
    assign fifo_empty = (rd_i == wr_i);
    assign fifo_data  = fmem[rd_i % 64];

    always #2.5 clk = ~clk;

    uart_tx uut (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_len(cfg_len),
        .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_two_stop(cfg_two_stop), .divisor(divisor),
        .fifo_empty(fifo_empty), .fifo_data(fifo_data),
        .fifo_pop(fifo_pop), .txd(txd), .busy(busy)
    );

    always @(posedge clk) if (rst_n && fifo_pop) rd_i <= rd_i + 1;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // Reference model: the frame as a list of bit levels and kinds
    int m_bits [0:15];
    int m_kind [0:15];   // 0 start, 1 data, 2 parity, 3 stop
    int m_nb = 0, m_pos = 0, m_sub = 0, m_cnt = 0;
    bit m_busy = 0;

    function automatic string kind_tag(input int k);
        case (k)
            0: return "R2 start";
            1: return "R3 data";
            2: return "R4 parity";
            default: return "R5 stop";
        endcase
    endfunction

    always @(negedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_busy = 0; m_pos = 0; m_sub = 0; m_cnt = 0; m_nb = 0;
        end else begin
            bit m_tick, exp_pop;
            int exp_txd, nd, ones;
            m_tick  = (divisor != 0) && (m_cnt >= int'(divisor) - 1);
            exp_pop = cfg_en && divisor != 0 && !fifo_empty &&
                      (!m_busy || (m_pos == m_nb - 1 && m_sub == 15 && m_tick));
            exp_txd = m_busy ? m_bits[m_pos] : 1;
            check(m_busy ? kind_tag(m_kind[m_pos]) : "R1 idle line", int'(txd), exp_txd);
            check("R7 busy", int'(busy), int'(m_busy));
            check("R6 pop", int'(fifo_pop), int'(exp_pop));
            // advance one cycle
            if (m_busy && m_tick) begin
                if (m_sub == 15) begin
                    m_sub = 0;
                    m_pos++;
                    if (m_pos == m_nb) m_busy = 0;
                end else m_sub++;
            end
            if (exp_pop) begin
                nd = 5 + int'(cfg_len);
                ones = 0;
                m_bits[0] = 0; m_kind[0] = 0;
                for (int i = 0; i < nd; i++) begin
                    m_bits[1 + i] = int'(fifo_data[i]);
                    m_kind[1 + i] = 1;
                    ones += int'(fifo_data[i]);
                end
                m_nb = 1 + nd;
                if (cfg_par_en) begin
                    m_bits[m_nb] = cfg_par_odd ? ((ones % 2 == 0) ? 1 : 0) : ones % 2;
                    m_kind[m_nb] = 2;
                    m_nb++;
                end
                m_bits[m_nb] = 1; m_kind[m_nb] = 3; m_nb++;
                if (cfg_two_stop) begin
                    m_bits[m_nb] = 1; m_kind[m_nb] = 3; m_nb++;
                end
                m_busy = 1; m_pos = 0; m_sub = 0;
            end
            m_cnt = (divisor == 0 || m_tick) ? 0 : m_cnt + 1;
        end
    end

    task automatic push(input logic [7:0] v);
        fmem[wr_i % 64] = v;
        wr_i = wr_i + 1;
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic wait_drain();
        step(2);
        while (!(fifo_empty && !busy)) step(1);
        step(3);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
            finish_run();
        end
    end

    initial begin
        step(3);
        // R1: reset state
        check("R1 reset txd", int'(txd), 1);
        check("R1 reset busy", int'(busy), 0);
        rst_n = 1'b1;
        cfg_en = 1'b1;
        step(2);

        // R3 eight bits, no parity, one stop, fastest rate
        push(8'hA5);
        wait_drain();

        // R4 even parity on seven bits
        cfg_len = 2'd2; cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
        push(8'h5B);
        wait_drain();

        // R4 odd parity, R5 two stops, five bits, back to back (R6)
        cfg_len = 2'd0; cfg_par_odd = 1'b1; cfg_two_stop = 1'b1; divisor = 16'd2;
        push(8'h13); push(8'h1F);
        wait_drain();

        // R8 slower divisor, six bits; R11 settings change mid-frame
        cfg_len = 2'd1; cfg_par_en = 1'b0; cfg_two_stop = 1'b0; divisor = 16'd3;
        push(8'h00); push(8'hFF); push(8'h2A);
        step(30);
        cfg_par_en = 1'b1; cfg_len = 2'd3; cfg_two_stop = 1'b1;
        step(40);
        check("R11 frame still busy", int'(busy), 1);
        wait_drain();

        // R10: disabled block leaves the FIFO untouched
        cfg_en = 1'b0;
        push(8'h77);
        step(300);
        check("R10 entry kept", int'(fifo_empty), 0);
        check("R10 not busy", int'(busy), 0);
        check("R10 line idle", int'(txd), 1);
        cfg_en = 1'b1;
        wait_drain();

        // R9: zero divisor freezes a frame in progress
        divisor = 16'd1;
        push(8'hC3);
        step(40);
        divisor = 16'd0;
        step(2);
        begin
            int held;
            held = int'(txd);
            step(100);
            check("R9 frozen busy", int'(busy), 1);
            check("R9 frozen txd", int'(txd), held);
        end
        divisor = 16'd1;
        wait_drain();

        finish_run();
    end

endmodule